// File: doc/BRIEF.md
# Conversion Interval Scheduler

This block paces analog-to-digital conversion requests for a touch sensing front end. Once enabled, it sends a one-cycle start pulse to the converter and waits for the converter to acknowledge completion before it sends the next one. After every group of four acknowledged conversions it holds off for a programmable quiet period, then begins the next group.

The quiet period comes from a 4-bit code held in a small write-only register. A code N gives a gap of (N+1) times 128 clock periods, so the gap ranges from 128 to 2048 clocks. The code is sampled at the moment a gap begins. Rewriting it while a gap is running therefore only changes later gaps. Dropping the enable returns the sequencer to idle and discards any partly finished group. A 2-bit status output shows whether the block is idle, converting or waiting.

Top module: `conv_gap_sched`

## Requirements
- R1: While reset is asserted and afterwards with enable low, `seq_state` is 2'b00 (idle) and `conv_start` is 0. The gap code resets to 2, which gives a 384-clock gap.
- R2: From idle, enable sampled high at a clock edge makes `conv_start` 1 for exactly one cycle in the next cycle, with `seq_state` at 2'b01.
- R3: After a start pulse, no further start is issued until `conv_done` is sampled high in a cycle where `conv_start` is low. A `conv_done` that coincides with the start pulse is ignored.
- R4: The fourth accepted acknowledgement of a group moves `seq_state` to 2'b10 (waiting) in the next cycle, with no start pulse. The first three acknowledgements each give a new start pulse in the next cycle.
- R5: The block stays in the waiting state for exactly (N+1)×128 consecutive cycles, where N is the gap code. In the cycle after that it shows 2'b01 with `conv_start` high.
- R6: Writing `cfg_wdata` with `cfg_we` high sets the gap code. Every value from 0 to 15 is honoured.
- R7: A code written while a gap is running does not change that gap. It applies to the next gap.
- R8: Enable low at a clock edge gives idle with no start in the next cycle, from any state, and discards the group count. After re-enable, four full acknowledgements are needed before the next gap.
- R9: `seq_state` encodes idle as 2'b00, converting as 2'b01 and waiting as 2'b10. The value 2'b11 never appears.
- R10: `conv_done` is ignored while idle or waiting. It does not shorten a gap and does not count toward a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| cfg_we | input | 1 | Gap code write strobe |
| cfg_wdata | input | 4 | Gap code value |
| conv_done | input | 1 | Converter completion acknowledge |
| conv_start | output | 1 | One-cycle conversion start pulse |
| seq_state | output | 2 | Status: 00 idle, 01 converting, 10 waiting |

## Verification
The properties assume that `en`, `conv_done` and `cfg_we` are synchronous to `clk` and hold known values once reset is released. They place no limit on when an acknowledgement may arrive. The bench changes every input only on falling clock edges and keeps acknowledgements to single-cycle pulses. It also deliberately sends acknowledgements that the block must ignore: during the start cycle, while idle and in the middle of a gap. This shows that the block's acceptance rule alone keeps it in step with the converter.

// File: rtl/gap_pkg.sv
package gap_pkg;

    // Sequencer status encoding, visible on seq_state
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CONV = 2'b01,
        ST_WAIT = 2'b10
    } seq_state_e;

endpackage

// File: rtl/gap_cfg_reg.sv
module gap_cfg_reg #(
    parameter int CODE_W     = 4,
    parameter int RESET_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] code
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.code = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= CODE_W'(RESET_CODE);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign code = cfg_q.code;

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CODE_W    = 4,
    parameter int UNIT_CLKS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              expired
);

    localparam int TMR_W = $clog2(UNIT_CLKS << CODE_W);
    localparam logic [TMR_W-1:0] UNIT_V = TMR_W'(UNIT_CLKS);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [TMR_W-1:0] load_val;

    // Gap of (code+1) units, counted down to zero inclusive
    assign load_val = ((TMR_W'(code) + TMR_W'(1)) * UNIT_V) - TMR_W'(1);

    always_comb begin
        tmr_d = tmr_q;
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.cnt = load_val;
        end else if (run && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/gap_group_ctr.sv
module gap_group_ctr #(
    parameter int GROUP_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int GRP_W = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1;

    typedef struct packed {
        logic [GRP_W-1:0] cnt;
    } grp_t;

    grp_t grp_d, grp_q;

    always_comb begin
        grp_d = grp_q;
        if (clr) begin
            grp_d.cnt = '0;
        end else if (inc) begin
            grp_d.cnt = grp_q.cnt + GRP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q.cnt <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign last = (grp_q.cnt == GRP_W'(GROUP_LEN - 1));

endmodule

// File: rtl/conv_gap_sched.sv
module conv_gap_sched #(
    parameter int CODE_W     = 4,
    parameter int UNIT_CLKS  = 128,
    parameter int GROUP_LEN  = 4,
    parameter int RESET_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_wdata,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [1:0]        seq_state
);

    import gap_pkg::*;

    typedef struct packed {
        seq_state_e state;
        logic       start;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CODE_W-1:0] code;
    logic tmr_clr, tmr_load, tmr_run, tmr_expired;
    logic grp_clr, grp_inc, grp_last;
    logic accept;

    gap_cfg_reg #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .code  (code)
    );

    gap_timer #(
        .CODE_W    (CODE_W),
        .UNIT_CLKS (UNIT_CLKS)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .load    (tmr_load),
        .run     (tmr_run),
        .code    (code),
        .expired (tmr_expired)
    );

    gap_group_ctr #(
        .GROUP_LEN (GROUP_LEN)
    ) i_group (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grp_clr),
        .inc   (grp_inc),
        .last  (grp_last)
    );

    // Acknowledge counts only while converting and not in the start cycle
    assign accept = (seq_q.state == ST_CONV) && !seq_q.start && conv_done;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        tmr_clr     = 1'b0;
        tmr_load    = 1'b0;
        tmr_run     = 1'b0;
        grp_clr     = 1'b0;
        grp_inc     = 1'b0;
        if (!en) begin
            seq_d.state = ST_IDLE;
            tmr_clr     = 1'b1;
            grp_clr     = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    seq_d.state = ST_CONV;
                    seq_d.start = 1'b1;
                end
                ST_CONV: begin
                    if (accept) begin
                        if (grp_last) begin
                            seq_d.state = ST_WAIT;
                            tmr_load    = 1'b1;
                            grp_clr     = 1'b1;
                        end else begin
                            grp_inc     = 1'b1;
                            seq_d.start = 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        seq_d.state = ST_CONV;
                        seq_d.start = 1'b1;
                    end else begin
                        tmr_run = 1'b1;
                    end
                end
                default: begin
                    seq_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.start <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start = seq_q.start;
    assign seq_state  = seq_q.state;

endmodule

// File: rtl/gap_sched_chk.sv
module gap_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       conv_done,
    input logic       conv_start,
    input logic [1:0] seq_state
);

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start)
        else $error("start pulse longer than one cycle");

    p_hold_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'b01 && !conv_start && !conv_done) |=> !conv_start)
        else $error("start issued without acknowledgement");

    p_no_start_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'b10) |-> !conv_start)
        else $error("start during gap");

    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'b10) |=> (seq_state != 2'b01 || conv_start))
        else $error("gap left without a start");

    p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (seq_state == 2'b00 && !conv_start))
        else $error("disable did not force idle");

    p_start_in_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (seq_state == 2'b01))
        else $error("start outside converting state");

    p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state != 2'b11)
        else $error("illegal status code");

endmodule

bind conv_gap_sched gap_sched_chk i_gap_sched_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .seq_state  (seq_state)
);

// File: tb/test_conv_gap_sched.sv
`timescale 1ns/1ps
module test_conv_gap_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       conv_done = 1'b0;
    logic       conv_start;
    logic [1:0] seq_state;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    conv_gap_sched i_conv_gap_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .seq_state  (seq_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion: start seen now, acknowledge after lat cycles
    task automatic do_conv(input int lat, input int wr_code, input bit early);
        chk("R2 start pulse", int'(conv_start), 1);
        chk("R9 converting code", int'(seq_state), 1);
        if (wr_code >= 0) begin
            cfg_we = 1'b1;
            cfg_wdata = 4'(wr_code);
        end
        if (early) conv_done = 1'b1;
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            conv_done = 1'b0;
            chk("R3 no start before done", int'(conv_start), 0);
            chk("R3 still converting", int'(seq_state), 1);
        end
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Measure the gap; optional write or stray done in its middle
    task automatic measure_gap(input int exp_len, input int wr_mid, input bit done_mid);
        int n = 0;
        chk("R4 gap entered", int'(seq_state), 2);
        chk("R4 no start at gap", int'(conv_start), 0);
        while (seq_state == 2'b10 && n < 5000) begin
            n++;
            if (n == 10 && wr_mid >= 0) begin
                cfg_we = 1'b1;
                cfg_wdata = 4'(wr_mid);
            end
            if (n == 20 && done_mid) conv_done = 1'b1;
            @(negedge clk);
            cfg_we = 1'b0;
            conv_done = 1'b0;
        end
        chk("R5 gap length", n, exp_len);
        chk("R5 start after gap", int'(conv_start), 1);
    endtask

    task automatic run_group(input int lat, input int wr_first, input int wr_mid,
                             input bit early, input bit done_mid, input int exp_len);
        for (int i = 0; i < 4; i++) begin
            do_conv(lat + i, (i == 0) ? wr_first : -1, early && (i == 1));
        end
        measure_gap(exp_len, wr_mid, done_mid);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle in reset", int'(seq_state), 0);
        chk("R1 no start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        // R10: acknowledgements while idle are ignored
        conv_done = 1'b1;
        repeat (3) @(negedge clk);
        conv_done = 1'b0;
        chk("R10 idle ignores done", int'(seq_state), 0);
        chk("R1 no start after reset", int'(conv_start), 0);

        en = 1'b1;
        @(negedge clk);
        // R1/R6: reset code 2 gives 384 clocks
        run_group(1, -1, -1, 1'b0, 1'b0, 384);

        // R6: sweep every code, written during the first conversion
        for (int c = 0; c < 16; c++) begin
            run_group(1 + (c % 3), c, -1, 1'b0, 1'b0, (c + 1) * 128);
        end

        // R7: write 0 mid-gap with code 15; current gap unchanged
        run_group(2, -1, 0, 1'b0, 1'b0, 2048);
        run_group(1, -1, -1, 1'b0, 1'b0, 128);

        // R3: done during start cycle ignored; R10: done mid-gap ignored
        run_group(1, 3, -1, 1'b1, 1'b1, 512);

        // R8: disable mid-group, stray done while idle, re-enable
        do_conv(1, -1, 1'b0);
        do_conv(2, -1, 1'b0);
        en = 1'b0;
        @(negedge clk);
        chk("R8 idle after disable", int'(seq_state), 0);
        chk("R8 no start after disable", int'(conv_start), 0);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R10 idle stays idle", int'(seq_state), 0);
        en = 1'b1;
        @(negedge clk);
        run_group(1, -1, -1, 1'b0, 1'b0, 512);

        // R8: disable during a gap, re-enable starts a conversion
        for (int i = 0; i < 4; i++) do_conv(1, -1, 1'b0);
        repeat (5) @(negedge clk);
        chk("R8 gap before disable", int'(seq_state), 2);
        en = 1'b0;
        @(negedge clk);
        chk("R8 gap aborted", int'(seq_state), 0);
        en = 1'b1;
        @(negedge clk);
        run_group(3, -1, -1, 1'b0, 1'b0, 512);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule